// File: doc/BRIEF.md
# Power-Mode and Thermal-Shutdown Control Register

This block is an 8-bit control register. It gates the chip's power stages and accepts requests to enter the two low-power modes. It also decides, for each of two driver groups, whether a high-temperature event shuts that group down automatically. Software writes the register through a simple write port, and the current contents are always visible on a read bus. Every field clears on a synchronous reset.

The two mode requests are guarded against accidental entry. A request is taken only when the written byte carries that single command bit, with every other bit of the upper six bits clear. A pending request drops as soon as any CPU interrupt request arrives. The thermal side keeps one latched shutdown strobe per driver group: one for the high-side group and one for the low-side group. A strobe latches when a high-temperature event occurs while that group's select bit is 0. Software releases the strobes by writing the enable bit again.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset, rd_data reads 0x00 and pstage_en, stop_req, sleep_req, hs_shutdn and ls_shutdn are all 0.
- R2: A write always stores bit 7 (power-stage enable), bit 4 (low-side keep), bit 3 (high-side keep), bit 2 and bits 1:0 from wr_data. The new value appears on rd_data in the cycle after the write, and pstage_en follows bit 7 in that same cycle.
- R3: A write is a Stop command only when wr_data[7:2] equals 6'b010000. It then sets stop_req, which reads back at bit 6, and clears any pending Sleep request.
- R4: A write is a Sleep command only when wr_data[7:2] equals 6'b001000. It then sets sleep_req, which reads back at bit 5, and clears any pending Stop request.
- R5: Any other write that sets bit 6 or bit 5 leaves stop_req and sleep_req unchanged, while the other fields are still stored. A write that sets both bit 6 and bit 5 counts as such a write.
- R6: A cpu_irq pulse clears stop_req and sleep_req in the next cycle. It wins over a Stop or Sleep command written in the same cycle.
- R7: stop_req and sleep_req are never 1 at the same time.
- R8: hot_evt while the stored bit 3 is 0 sets hs_shutdn in the next cycle. While bit 3 is 1, hot_evt leaves hs_shutdn unchanged.
- R9: hot_evt while the stored bit 4 is 0 sets ls_shutdn in the next cycle. While bit 4 is 1, hot_evt leaves ls_shutdn unchanged.
- R10: A set shutdown strobe stays set until a write with bit 7 = 1 clears it. If hot_evt arrives in the same cycle as that write, hot_evt wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Byte to write |
| cpu_irq | input | 1 | Any CPU interrupt request |
| hot_evt | input | 1 | High-temperature event |
| rd_data | output | 8 | Current register contents |
| pstage_en | output | 1 | Power-stage enable |
| stop_req | output | 1 | Pending Stop request |
| sleep_req | output | 1 | Pending Sleep request |
| hs_shutdn | output | 1 | Latched high-side driver shutdown |
| ls_shutdn | output | 1 | Latched low-side driver shutdown |

## Verification
There are two places where functions can meet in one cycle. The first is a valid Stop command written in the same cycle as a cpu_irq pulse. The bench drives both inputs on one clock edge and expects stop_req to stay 0 and bit 6 of the read bus to be clear. The second is a thermal event that arrives together with the enable write that would release the strobes. The bench expects both strobes to remain set, because the set takes priority over the release.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int DATA_W    = 8;
  localparam int BIT_PWR   = 7;
  localparam int BIT_STOP  = 6;
  localparam int BIT_SLEEP = 5;
  localparam int BIT_LSK   = 4;
  localparam int BIT_HSK   = 3;
  localparam int BIT_VSEL  = 2;
  localparam int CMD_LO    = 2;
  localparam int NUM_GRP   = 2;  // group 0 high-side, group 1 low-side

  typedef struct packed {
    logic       pwr_en;
    logic       stop;
    logic       sleep;
    logic       ls_keep;
    logic       hs_keep;
    logic       vsel;
    logic [1:0] fsel;
  } ctrl_t;
endpackage

// File: rtl/pmc_cmd_filter.sv
module pmc_cmd_filter #(
  parameter int DATA_W = 8,
  parameter int CMD_LO = 2,
  parameter int NUM_CMD = 2,
  parameter int CMD_POS [NUM_CMD] = '{6, 5}
) (
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [NUM_CMD-1:0] cmd_ok
);
  localparam int UPPER_W = DATA_W - CMD_LO;

  logic [UPPER_W-1:0] upper;
  assign upper = wr_data[DATA_W-1:CMD_LO];

  // A command is accepted only when its own bit is the sole bit set above CMD_LO
  for (genvar g = 0; g < NUM_CMD; g++) begin : g_cmd
    localparam logic [UPPER_W-1:0] PATTERN = UPPER_W'(1) << (CMD_POS[g] - CMD_LO);
    assign cmd_ok[g] = wr_en && (upper == PATTERN);
  end
endmodule

// File: rtl/pmc_mode_req.sv
module pmc_mode_req (
  input  logic clk,
  input  logic rst,
  input  logic cpu_irq,
  input  logic stop_ok,
  input  logic sleep_ok,
  output logic stop_q,
  output logic sleep_q
);
  // Interrupt has priority; an accepted command replaces the other request
  always_ff @(posedge clk) begin
    if (rst || cpu_irq) begin
      stop_q  <= 1'b0;
      sleep_q <= 1'b0;
    end else if (stop_ok) begin
      stop_q  <= 1'b1;
      sleep_q <= 1'b0;
    end else if (sleep_ok) begin
      stop_q  <= 1'b0;
      sleep_q <= 1'b1;
    end
  end
endmodule

// File: rtl/pmc_therm_latch.sv
module pmc_therm_latch #(
  parameter int NUM_GRP = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               hot_evt,
  input  logic               rearm,
  input  logic [NUM_GRP-1:0] keep,
  output logic [NUM_GRP-1:0] shut
);
  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    always_ff @(posedge clk) begin
      if (rst)
        shut[g] <= 1'b0;
      else if (hot_evt && !keep[g])
        shut[g] <= 1'b1;   // set wins over re-arm
      else if (rearm)
        shut[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cpu_irq,
  input  logic              hot_evt,
  output logic [DATA_W-1:0] rd_data,
  output logic              pstage_en,
  output logic              stop_req,
  output logic              sleep_req,
  output logic              hs_shutdn,
  output logic              ls_shutdn
);
  localparam int NUM_CMD = 2;

  logic               pwr_en_q, ls_keep_q, hs_keep_q, vsel_q;
  logic [1:0]         fsel_q;
  logic [NUM_CMD-1:0] cmd_ok;
  logic               stop_q, sleep_q;
  logic [NUM_GRP-1:0] keep_vec, shut_vec;
  ctrl_t              view;

  always_ff @(posedge clk) begin
    if (rst) begin
      pwr_en_q  <= 1'b0;
      ls_keep_q <= 1'b0;
      hs_keep_q <= 1'b0;
      vsel_q    <= 1'b0;
      fsel_q    <= 2'b00;
    end else if (wr_en) begin
      pwr_en_q  <= wr_data[BIT_PWR];
      ls_keep_q <= wr_data[BIT_LSK];
      hs_keep_q <= wr_data[BIT_HSK];
      vsel_q    <= wr_data[BIT_VSEL];
      fsel_q    <= wr_data[1:0];
    end
  end

  pmc_cmd_filter #(
    .DATA_W (DATA_W),
    .CMD_LO (CMD_LO),
    .NUM_CMD(NUM_CMD),
    .CMD_POS('{BIT_STOP, BIT_SLEEP})
  ) cmd_i (
    .wr_en  (wr_en),
    .wr_data(wr_data),
    .cmd_ok (cmd_ok)
  );

  pmc_mode_req mode_i (
    .clk     (clk),
    .rst     (rst),
    .cpu_irq (cpu_irq),
    .stop_ok (cmd_ok[0]),
    .sleep_ok(cmd_ok[1]),
    .stop_q  (stop_q),
    .sleep_q (sleep_q)
  );

  assign keep_vec = {ls_keep_q, hs_keep_q};

  pmc_therm_latch #(.NUM_GRP(NUM_GRP)) therm_i (
    .clk    (clk),
    .rst    (rst),
    .hot_evt(hot_evt),
    .rearm  (wr_en && wr_data[BIT_PWR]),
    .keep   (keep_vec),
    .shut   (shut_vec)
  );

  always_comb begin
    view.pwr_en  = pwr_en_q;
    view.stop    = stop_q;
    view.sleep   = sleep_q;
    view.ls_keep = ls_keep_q;
    view.hs_keep = hs_keep_q;
    view.vsel    = vsel_q;
    view.fsel    = fsel_q;
  end

  assign rd_data   = view;
  assign pstage_en = pwr_en_q;
  assign stop_req  = stop_q;
  assign sleep_req = sleep_q;
  assign hs_shutdn = shut_vec[0];
  assign ls_shutdn = shut_vec[1];
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       cpu_irq,
  input logic       hot_evt,
  input logic [7:0] rd_data,
  input logic       pstage_en,
  input logic       stop_req,
  input logic       sleep_req,
  input logic       hs_shutdn,
  input logic       ls_shutdn
);
  AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (rd_data == 8'h00 && !hs_shutdn && !ls_shutdn)); // R1
  AST_PWR_FOLLOW: assert property (@(posedge clk) disable iff (rst) wr_en |=> (pstage_en == $past(wr_data[7]))); // R2
  AST_STOP_GUARD: assert property (@(posedge clk) disable iff (rst) $rose(stop_req) |-> $past(wr_en && wr_data[7:2] == 6'b010000)); // R3
  AST_SLEEP_GUARD: assert property (@(posedge clk) disable iff (rst) $rose(sleep_req) |-> $past(wr_en && wr_data[7:2] == 6'b001000)); // R4
  AST_IRQ_CLEAR: assert property (@(posedge clk) disable iff (rst) cpu_irq |=> (!stop_req && !sleep_req)); // R6
  AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst) $onehot0({stop_req, sleep_req})); // R7
  AST_HS_SET: assert property (@(posedge clk) disable iff (rst) (hot_evt && !rd_data[3]) |=> hs_shutdn); // R8
  AST_LS_SET: assert property (@(posedge clk) disable iff (rst) (hot_evt && !rd_data[4]) |=> ls_shutdn); // R9
  AST_HS_HOLD: assert property (@(posedge clk) disable iff (rst) (hs_shutdn && !(wr_en && wr_data[7])) |=> hs_shutdn); // R10
endmodule

bind pwr_mode_ctrl pmc_checker chk_i (.*);

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       cpu_irq = 1'b0;
  logic       hot_evt = 1'b0;
  logic [7:0] rd_data;
  logic       pstage_en, stop_req, sleep_req, hs_shutdn, ls_shutdn;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .cpu_irq(cpu_irq), .hot_evt(hot_evt), .rd_data(rd_data),
    .pstage_en(pstage_en), .stop_req(stop_req), .sleep_req(sleep_req),
    .hs_shutdn(hs_shutdn), .ls_shutdn(ls_shutdn)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  // drive on the falling edge, sample on the next falling edge
  task automatic wr(input logic [7:0] d, input logic irq = 1'b0, input logic hot = 1'b0);
    wr_en = 1'b1; wr_data = d; cpu_irq = irq; hot_evt = hot;
    @(negedge clk);
    wr_en = 1'b0; cpu_irq = 1'b0; hot_evt = 1'b0;
  endtask

  task automatic pulse(input logic irq, input logic hot);
    cpu_irq = irq; hot_evt = hot;
    @(negedge clk);
    cpu_irq = 1'b0; hot_evt = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 rd_data", rd_data, 8'h00);
    chk("R1 outputs", {3'b0, pstage_en, stop_req, sleep_req, hs_shutdn, ls_shutdn}, 8'h00);
  endtask

  task automatic t_plain();
    wr(8'h9F);
    chk("R2 store", rd_data, 8'h9F);
    chk("R2 pstage_en", {7'b0, pstage_en}, 8'h01);
    wr(8'h00);
    chk("R2 clear", rd_data, 8'h00);
  endtask

  task automatic t_cmds();
    wr(8'h43);
    chk("R3 stop accepted", rd_data, 8'h43);
    chk("R3 stop_req", {7'b0, stop_req}, 8'h01);
    wr(8'h20);
    chk("R4 sleep accepted", rd_data, 8'h20);
    chk("R7 stop dropped", {6'b0, stop_req, sleep_req}, 8'h01);
  endtask

  task automatic t_reject();
    wr(8'h60);
    chk("R5 both bits rejected", rd_data, 8'h20);
    wr(8'hC0);
    chk("R5 stop with enable rejected", rd_data, 8'hA0);
    chk("R5 requests unchanged", {6'b0, stop_req, sleep_req}, 8'h01);
    wr(8'h24);
    chk("R5 sleep with bit2 rejected", rd_data, 8'h24);
  endtask

  task automatic t_irq();
    pulse(1'b1, 1'b0);
    chk("R6 irq clears", {6'b0, stop_req, sleep_req}, 8'h00);
    chk("R6 fields kept", rd_data, 8'h04);
    wr(8'h40, 1'b1);
    chk("R6 irq beats stop", rd_data, 8'h00);
  endtask

  task automatic t_thermal();
    wr(8'h08);
    pulse(1'b0, 1'b1);
    chk("R8 hs kept", {7'b0, hs_shutdn}, 8'h00);
    chk("R9 ls shut", {7'b0, ls_shutdn}, 8'h01);
    wr(8'h10);
    pulse(1'b0, 1'b1);
    chk("R8 hs shut", {7'b0, hs_shutdn}, 8'h01);
    wr(8'h00);
    chk("R10 hold without enable", {6'b0, hs_shutdn, ls_shutdn}, 8'h03);
    wr(8'h80);
    chk("R10 enable releases", {6'b0, hs_shutdn, ls_shutdn}, 8'h00);
    wr(8'h80, 1'b0, 1'b1);
    chk("R10 event beats release", {6'b0, hs_shutdn, ls_shutdn}, 8'h03);
  endtask

  initial begin
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_cmds();
    t_reject();
    t_irq();
    t_thermal();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule